// File: doc/BRIEF.md
# UART Interrupt Output Generator

This block produces the single interrupt line of a 16550-style serial port, together with a 3-bit code that names the most urgent pending cause. It looks at how full the transmit and receive paths are and at whether those paths run as single-byte holding registers or as 16-entry FIFOs. It sets the line when the transmitter needs feeding or the receiver needs draining. The choice between the two modes comes from the FIFO enable bit of the FIFO control register.

In FIFO mode, programmable thresholds decide when the line is raised. The receive threshold is picked by one 2-bit code and the transmit threshold by another. A receive data timeout is also built in. It counts character-time ticks while received bytes sit untouched in the FIFO. Each of the three causes can be masked with its own enable bit. The line and the code are registered, so both show the inputs that were present at the previous clock edge.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst` is high, `irq_pin` is 0 and `irq_code` is 3'b001 (none).
- R2: Holding mode (`fifo_en`=0), with only transmit enabled: `irq_pin` is 1 exactly when `tx_count` is 0.
- R3: Holding mode, with receive data enabled: `irq_pin` is 1 whenever `rx_count` is non-zero.
- R4: FIFO mode: the transmit cause is pending when `tx_count` is less than or equal to the transmit level. `tx_trig_sel` values 0,1,2,3 select levels 0,4,8,12.
- R5: FIFO mode: the receive data cause is pending when `rx_count` is greater than or equal to the receive level. `rx_trig_sel` values 0,1,2,3 select levels 1,4,8,14.
- R6: FIFO mode: the timeout cause becomes pending on the edge that samples the 4th `char_tick` counted while the receive FIFO is non-empty and neither `rx_push` nor `rx_pop` is asserted. An edge that samples `rx_push`, `rx_pop` or an empty FIFO clears the count and the timeout cause.
- R7: Each cause is masked by its own enable (`ier_tx_en`, `ier_rx_en`, `ier_tmo_en`). With all three low, `irq_pin` stays 0.
- R8: `irq_code` reports the highest pending unmasked cause: 3'b110 for timeout, 3'b100 for receive data, 3'b010 for transmit, 3'b001 for none. `irq_pin` is 1 exactly when the code is not none.
- R9: An edge that samples `fcr_wr` high gives `irq_pin` 0 and code none for that cycle, and restarts the timeout count.
- R10: Outputs are registered. They reflect the inputs sampled at the preceding rising edge.
- R11: The timeout cause never becomes pending in holding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects holding-register mode |
| fcr_wr | input | 1 | Strobe: FIFO control register written this cycle |
| tx_trig_sel | input | 2 | Transmit threshold select |
| rx_trig_sel | input | 2 | Receive threshold select |
| tx_count | input | 5 | Bytes waiting in the transmit path |
| rx_count | input | 5 | Bytes waiting in the receive path |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte left the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| ier_tx_en | input | 1 | Transmit cause enable |
| ier_rx_en | input | 1 | Receive data cause enable |
| ier_tmo_en | input | 1 | Receive timeout cause enable |
| irq_pin | output | 1 | Interrupt line, high when a cause is pending |
| irq_code | output | 3 | Highest-priority pending cause |

## Verification
Directed cases first step the occupancy counts across each mode's boundary: empty against one byte in holding mode, and threshold against threshold plus or minus one in FIFO mode. This separates the off-by-one compare errors and shows that the transmit and receive directions have opposite sense. A timeout sequence counts ticks up to the fourth and then issues a push. This exposes a counter that fires early or late, or one that does not clear. Masked, holding-mode-tick and control-write cases show that the enables, the mode restriction on timeouts and the clear all act as required. A long seeded random run with sparse push, pop, mode and control-write events then mixes all causes at once. That run tests the priority order against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        IRQ_NONE  = 3'b001,
        IRQ_TX    = 3'b010,
        IRQ_RXDAT = 3'b100,
        IRQ_RXTMO = 3'b110
    } irq_code_e;

    function automatic logic [31:0] rx_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'd1;
            2'd1:    return 32'd4;
            2'd2:    return 32'd8;
            default: return 32'd14;
        endcase
    endfunction

    function automatic logic [31:0] tx_level(input logic [1:0] sel);
        return 32'(sel) * 32'd4;
    endfunction

endpackage

// File: rtl/uart_irq_cond.sv
module uart_irq_cond #(
    parameter int CNT_W = 5
) (
    input  logic             fifo_en,
    input  logic [1:0]       tx_trig_sel,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    output logic             tx_hit,
    output logic             rx_hit
);
    import uart_irq_pkg::*;

    logic [31:0] tx_cnt_w;
    logic [31:0] rx_cnt_w;

    assign tx_cnt_w = 32'(tx_count);
    assign rx_cnt_w = 32'(rx_count);

    always_comb begin
        if (fifo_en) begin
            tx_hit = (tx_cnt_w <= tx_level(tx_trig_sel));
            rx_hit = (rx_cnt_w >= rx_level(rx_trig_sel));
        end else begin
            tx_hit = (tx_cnt_w == 32'd0);
            rx_hit = (rx_cnt_w != 32'd0);
        end
    end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en,
    input  logic fcr_wr,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    output logic hit_d
);
    localparam int TW = $clog2(TO_CHARS + 1);

    logic [TW-1:0] cnt_d;
    logic [TW-1:0] cnt_q;
    logic          clr;

    always_comb begin
        clr   = fcr_wr || !fifo_en || !rx_nonempty || rx_push || rx_pop;
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (char_tick && (cnt_q != TW'(TO_CHARS))) begin
            cnt_d = cnt_q + 1'b1;
        end
        hit_d = (cnt_d == TW'(TO_CHARS));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio (
    input  logic       tx_req,
    input  logic       rx_req,
    input  logic       tmo_req,
    output logic       pin,
    output logic [2:0] code
);
    import uart_irq_pkg::*;

    always_comb begin
        if (tmo_req)     code = IRQ_RXTMO;
        else if (rx_req) code = IRQ_RXDAT;
        else if (tx_req) code = IRQ_TX;
        else             code = IRQ_NONE;
        pin = tmo_req || rx_req || tx_req;
    end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             fcr_wr,
    input  logic [1:0]       tx_trig_sel,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             ier_tx_en,
    input  logic             ier_rx_en,
    input  logic             ier_tmo_en,
    output logic             irq_pin,
    output logic [2:0]       irq_code
);
    import uart_irq_pkg::*;

    typedef struct packed {
        logic       pin;
        logic [2:0] code;
    } out_t;

    out_t st_d;
    out_t st_q;

    logic       tx_hit;
    logic       rx_hit;
    logic       tmo_hit;
    logic       tx_req;
    logic       rx_req;
    logic       tmo_req;
    logic       pin_nxt;
    logic [2:0] code_nxt;

    uart_irq_cond #(.CNT_W(CNT_W)) u_cond (
        .fifo_en     (fifo_en),
        .tx_trig_sel (tx_trig_sel),
        .rx_trig_sel (rx_trig_sel),
        .tx_count    (tx_count),
        .rx_count    (rx_count),
        .tx_hit      (tx_hit),
        .rx_hit      (rx_hit)
    );

    uart_irq_tmo #(.TO_CHARS(TO_CHARS)) u_tmo (
        .clk         (clk),
        .rst         (rst),
        .fifo_en     (fifo_en),
        .fcr_wr      (fcr_wr),
        .rx_nonempty (rx_count != '0),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .char_tick   (char_tick),
        .hit_d       (tmo_hit)
    );

    assign tx_req  = tx_hit  && ier_tx_en  && !fcr_wr;
    assign rx_req  = rx_hit  && ier_rx_en  && !fcr_wr;
    assign tmo_req = tmo_hit && ier_tmo_en;

    uart_irq_prio u_prio (
        .tx_req  (tx_req),
        .rx_req  (rx_req),
        .tmo_req (tmo_req),
        .pin     (pin_nxt),
        .code    (code_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pin  = pin_nxt;
        st_d.code = code_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pin  <= 1'b0;
            st_q.code <= IRQ_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pin  = st_q.pin;
    assign irq_code = st_q.code;
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             fcr_wr,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             ier_tx_en,
    input logic             ier_rx_en,
    input logic             ier_tmo_en,
    input logic             irq_pin,
    input logic [2:0]       irq_code
);
    assert_pin_code_agree_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pin == (irq_code != 3'b001));

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_code == 3'b001) || (irq_code == 3'b010) ||
        (irq_code == 3'b100) || (irq_code == 3'b110));

    assert_fcr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        fcr_wr |=> (!irq_pin && irq_code == 3'b001));

    assert_all_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (!ier_tx_en && !ier_rx_en && !ier_tmo_en) |=> !irq_pin);

    assert_tmo_fifo_only_R11: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> irq_code != 3'b110);

    assert_tmo_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> irq_code != 3'b110);

    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !fcr_wr && ier_tx_en && tx_count == '0) |=> irq_pin);

    assert_rx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !fcr_wr && ier_rx_en && rx_count != '0) |=> irq_code == 3'b100);
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/uart_irq_gen_bench.sv
`timescale 1ns/1ps
module uart_irq_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [1:0] tx_trig_sel = 2'd0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic [4:0] tx_count = 5'd0;
    logic [4:0] rx_count = 5'd0;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic       ier_tx_en = 1'b1;
    logic       ier_rx_en = 1'b1;
    logic       ier_tmo_en = 1'b1;
    logic       irq_pin;
    logic [2:0] irq_code;

    int nchk = 0;
    int nfail = 0;
    int mcnt = 0;
    logic       exp_pin = 1'b0;
    logic [2:0] exp_code = 3'b001;

    always #4 clk = ~clk;

    uart_irq_gen u_uart_irq_gen (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .fcr_wr(fcr_wr),
        .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
        .tx_count(tx_count), .rx_count(rx_count),
        .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
        .ier_tx_en(ier_tx_en), .ier_rx_en(ier_rx_en), .ier_tmo_en(ier_tmo_en),
        .irq_pin(irq_pin), .irq_code(irq_code)
    );

    function automatic int rx_lvl(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int tx_lvl(input logic [1:0] s);
        return 4 * int'(s);
    endfunction

    task automatic model_update();
        logic t, r, o;
        if (rst) begin
            mcnt = 0; exp_pin = 1'b0; exp_code = 3'b001;
            return;
        end
        if (fcr_wr || !fifo_en || rx_count == 0 || rx_push || rx_pop) mcnt = 0;
        else if (char_tick && mcnt < 4) mcnt = mcnt + 1;
        o = (mcnt == 4) && ier_tmo_en;
        if (fifo_en) begin
            t = int'(tx_count) <= tx_lvl(tx_trig_sel);
            r = int'(rx_count) >= rx_lvl(rx_trig_sel);
        end else begin
            t = (tx_count == 0);
            r = (rx_count != 0);
        end
        t = t && ier_tx_en && !fcr_wr;
        r = r && ier_rx_en && !fcr_wr;
        exp_pin  = t || r || o;
        exp_code = o ? 3'b110 : r ? 3'b100 : t ? 3'b010 : 3'b001;
    endtask

    task automatic check(input string tag);
        nchk++;
        if (irq_pin !== exp_pin || irq_code !== exp_code) begin
            nfail++;
            $display("FAIL %s: pin=%0b code=%03b, expected pin=%0b code=%03b",
                     tag, irq_pin, irq_code, exp_pin, exp_code);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_600_000;
        nchk++; nfail++;
        $display("FAIL watchdog: run hung, actual running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc("R1 reset");
        rst = 1'b0;
        // R2 holding transmit
        ier_rx_en = 1'b0; ier_tmo_en = 1'b0;
        tx_count = 5'd1; cyc("R2 tx busy");
        tx_count = 5'd0; cyc("R2 tx empty");
        // R3 holding receive, R8 priority over transmit
        ier_rx_en = 1'b1; ier_tmo_en = 1'b1;
        rx_count = 5'd1; cyc("R3 rx held, R8 prio");
        rx_count = 5'd0; tx_count = 5'd3; cyc("R3 rx empty");
        // R9 control write while switching to FIFO mode
        fifo_en = 1'b1; fcr_wr = 1'b1; tx_count = 5'd0; cyc("R9 fcr clear");
        fcr_wr = 1'b0; cyc("R10 after clear");
        // R4 transmit level boundary
        tx_trig_sel = 2'd1; tx_count = 5'd5; cyc("R4 tx above level");
        tx_count = 5'd4; cyc("R4 tx at level");
        // R5 receive level boundary
        tx_count = 5'd9; rx_trig_sel = 2'd3; rx_count = 5'd13; cyc("R5 rx below level");
        rx_count = 5'd14; cyc("R5 rx at level");
        // R6 timeout
        rx_count = 5'd2; char_tick = 1'b1;
        for (int i = 0; i < 5; i++) cyc("R6 timeout count");
        char_tick = 1'b0; rx_push = 1'b1; cyc("R6 push clears");
        rx_push = 1'b0; char_tick = 1'b1;
        for (int i = 0; i < 4; i++) cyc("R6 recount");
        char_tick = 1'b0; rx_pop = 1'b1; cyc("R6 pop clears");
        rx_pop = 1'b0;
        // R7 all masked
        ier_tx_en = 1'b0; ier_rx_en = 1'b0; ier_tmo_en = 1'b0; tx_count = 5'd0;
        char_tick = 1'b1;
        for (int i = 0; i < 5; i++) cyc("R7 masked");
        ier_tx_en = 1'b1; ier_rx_en = 1'b1; ier_tmo_en = 1'b1;
        // R11 holding mode with ticks
        fifo_en = 1'b0; tx_count = 5'd1;
        for (int i = 0; i < 6; i++) cyc("R11 no tmo in holding");
        // random mix
        void'($urandom(32'd4242));
        fifo_en = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) tx_count = 5'($urandom_range(16));
            if ($urandom_range(7) == 0) rx_count = 5'($urandom_range(16));
            if ($urandom_range(15) == 0) tx_trig_sel = 2'($urandom);
            if ($urandom_range(15) == 0) rx_trig_sel = 2'($urandom);
            rx_push    = ($urandom_range(11) == 0);
            rx_pop     = ($urandom_range(11) == 0);
            char_tick  = ($urandom_range(1) == 0);
            fcr_wr     = ($urandom_range(39) == 0);
            if ($urandom_range(59) == 0) fifo_en = ~fifo_en;
            ier_tx_en  = ($urandom_range(7) != 0);
            ier_rx_en  = ($urandom_range(7) != 0);
            ier_tmo_en = ($urandom_range(7) != 0);
            cyc("R10 random R8 R6");
        end
        rst = 1'b1; cyc("R1 reset again");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule